// File: doc/BRIEF.md
# Double-Buffered 10-bit PWM Generator

This block produces a single pulse-width-modulated output from a system clock. An 8-bit up-counting timer, extended below by two sub-count bits, forms a 10-bit time base. A selectable prescaler sets how many system clocks pass per time-base step: 1, 4 or 16. An 8-bit period limit sets where each PWM period ends. When the timer sits at that limit and its next step comes due, the time base restarts from zero instead of advancing.

Software writes the 10-bit duty value at any time as an 8-bit upper part and a 2-bit lower part. A shadow copy of that value is captured only at the period boundary, so the output never sees a half-written value or a mid-period change. The output rises at each boundary, unless the captured duty value is zero. It falls when the time base reaches the captured duty value. A duty value at or above the period length in time-base steps never matches, so the output stays high for the whole period.

Top module: `pwm_dbuf_gen`

## Requirements
- R1: After reset, `pwm_o` is 0 and `duty_shadow_o` is 0.
- R2: At each period boundary, `pwm_o` goes to 1 if the newly captured duty value is non-zero. If that value is zero, `pwm_o` stays 0 for the whole period.
- R3: At each period boundary, `duty_shadow_o` takes the value `{duty_hi_i, duty_lo_i}`. `duty_hi_i` supplies bits 9:2 and `duty_lo_i` supplies bits 1:0.
- R4: Changes to `duty_hi_i` or `duty_lo_i` between boundaries change neither `duty_shadow_o` nor the high time of the current period. They take effect from the next boundary.
- R5: A period lasts exactly (`period_i` + 1) × 4 × P system clocks, where P is the prescale ratio.
- R6: For a duty value D with 0 < D < 4 × (`period_i` + 1), `pwm_o` is high for exactly D × P system clocks per period. This includes odd D, which resolves through the two sub-count bits.
- R7: If D ≥ 4 × (`period_i` + 1), `pwm_o` stays high for the entire period.
- R8: `psc_sel_i` selects P as follows: 2'b00 gives 1, 2'b01 gives 4, and 2'b10 or 2'b11 give 16. The time base holds between prescaler ticks.
- R9: While `en_i` is 0, `pwm_o` is 0 from the next clock and the time base is held at zero. After `en_i` rises, the first boundary comes after a full period. `pwm_o` stays 0 until that boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Run enable; when low, the counters are cleared and the output is held low |
| period_i | input | 8 | Period limit for the 8-bit timer |
| duty_hi_i | input | 8 | Upper 8 bits of the requested duty value |
| duty_lo_i | input | 2 | Lower 2 bits of the requested duty value |
| psc_sel_i | input | 2 | Prescale select (00: 1, 01: 4, 1x: 16) |
| pwm_o | output | 1 | PWM output |
| duty_shadow_o | output | 10 | Read-only copy of the captured duty value |

## Verification
The bench builds the block with its default widths: an 8-bit timer, two sub-count bits and a 4-bit prescale divider. With these widths it can reach the largest period limit of 255 with a duty of 1023, which matches on the very last time-base step. The same widths cover every prescale code, including the duplicate 16 encoding. It also covers duty values exactly at and above the period length, where the output must stay high. Directed runs check three cases: the first period after enable, a duty rewrite just after a rising edge, and the drop of the output on disable.

// File: rtl/pwm_dbuf_pkg.sv
package pwm_dbuf_pkg;

  // Width of the system-clock divider behind each time-base step
  localparam int unsigned DIV_W = 4;

  // Prescale select to divider terminal value (ratio - 1)
  function automatic logic [DIV_W-1:0] psc_limit(input logic [1:0] sel);
    logic [DIV_W-1:0] lim;
    case (sel)
      2'b00:   lim = DIV_W'(0);
      2'b01:   lim = DIV_W'(3);
      default: lim = DIV_W'(15);
    endcase
    return lim;
  endfunction

  // Next output level from the three events that can move it
  function automatic logic pwm_next(input logic run,
                                    input logic boundary,
                                    input logic duty_nonzero,
                                    input logic hit,
                                    input logic cur);
    logic nxt;
    if (!run)          nxt = 1'b0;
    else if (boundary) nxt = duty_nonzero;
    else if (hit)      nxt = 1'b0;
    else               nxt = cur;
    return nxt;
  endfunction

endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler
  import pwm_dbuf_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en_i,
  input  logic [1:0] sel_i,
  output logic       tick_o
);

  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] limit_w;

  assign limit_w = psc_limit(sel_i);
  assign tick_o  = en_i && (div_q >= limit_w);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      div_q <= '0;
    else if (!en_i)  div_q <= '0;
    else if (tick_o) div_q <= '0;
    else             div_q <= div_q + 1'b1;
  end

endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase #(
  parameter int unsigned CNT_W = 8,
  parameter int unsigned SUB_W = 2,
  localparam int unsigned TB_W = CNT_W + SUB_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] period_i,
  output logic [TB_W-1:0]  tb_q,
  output logic [TB_W-1:0]  tb_nxt,
  output logic             wrap_o
);

  logic sub_full_w;
  logic at_top_w;

  assign sub_full_w = &tb_q[SUB_W-1:0];
  assign at_top_w   = (tb_q[TB_W-1:SUB_W] == period_i);
  assign wrap_o     = tick_i && sub_full_w && at_top_w;

  always_comb begin
    if (!en_i || wrap_o) tb_nxt = '0;
    else if (tick_i)     tb_nxt = tb_q + 1'b1;
    else                 tb_nxt = tb_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tb_q <= '0;
    else        tb_q <= tb_nxt;
  end

endmodule

// File: rtl/pwm_duty_shadow.sv
module pwm_duty_shadow #(
  parameter int unsigned HI_W = 8,
  parameter int unsigned LO_W = 2,
  localparam int unsigned DUTY_W = HI_W + LO_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [HI_W-1:0]   hi_i,
  input  logic [LO_W-1:0]   lo_i,
  output logic [DUTY_W-1:0] req_o,
  output logic [DUTY_W-1:0] shadow_q
);

  assign req_o = {hi_i, lo_i};

  // Upper part and fine latch held as separate fields
  logic [HI_W-1:0] hi_q;
  logic [LO_W-1:0] lo_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q <= '0;
      lo_q <= '0;
    end else if (load_i) begin
      hi_q <= hi_i;
      lo_q <= lo_i;
    end
  end

  assign shadow_q = {hi_q, lo_q};

endmodule

// File: rtl/pwm_out_stage.sv
module pwm_out_stage
  import pwm_dbuf_pkg::*;
#(
  parameter int unsigned TB_W = 10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en_i,
  input  logic            tick_i,
  input  logic            wrap_i,
  input  logic [TB_W-1:0] tb_nxt_i,
  input  logic [TB_W-1:0] shadow_i,
  input  logic [TB_W-1:0] req_i,
  output logic            match_o,
  output logic            pwm_q
);

  // Compare against the value the time base is about to take,
  // so the fall lands on the same edge the time base reaches the duty value.
  assign match_o = tick_i && !wrap_i && (tb_nxt_i == shadow_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pwm_q <= 1'b0;
    else        pwm_q <= pwm_next(en_i, wrap_i, |req_i, match_o, pwm_q);
  end

endmodule

// File: rtl/pwm_dbuf_gen.sv
module pwm_dbuf_gen #(
  parameter int unsigned CNT_W = 8,
  parameter int unsigned SUB_W = 2,
  localparam int unsigned TB_W = CNT_W + SUB_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic [CNT_W-1:0] period_i,
  input  logic [CNT_W-1:0] duty_hi_i,
  input  logic [SUB_W-1:0] duty_lo_i,
  input  logic [1:0]       psc_sel_i,
  output logic             pwm_o,
  output logic [TB_W-1:0]  duty_shadow_o
);

  // Named internal events, visible to the bound checker
  logic            tick_w;
  logic            wrap_w;
  logic            match_w;
  logic [TB_W-1:0] tb_q;
  logic [TB_W-1:0] tb_nxt;
  logic [TB_W-1:0] req_w;

  pwm_prescaler u_psc (
    .clk    (clk),
    .rst_n  (rst_n),
    .en_i   (en_i),
    .sel_i  (psc_sel_i),
    .tick_o (tick_w)
  );

  pwm_timebase #(.CNT_W(CNT_W), .SUB_W(SUB_W)) u_tb (
    .clk      (clk),
    .rst_n    (rst_n),
    .en_i     (en_i),
    .tick_i   (tick_w),
    .period_i (period_i),
    .tb_q     (tb_q),
    .tb_nxt   (tb_nxt),
    .wrap_o   (wrap_w)
  );

  pwm_duty_shadow #(.HI_W(CNT_W), .LO_W(SUB_W)) u_shd (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_i   (wrap_w),
    .hi_i     (duty_hi_i),
    .lo_i     (duty_lo_i),
    .req_o    (req_w),
    .shadow_q (duty_shadow_o)
  );

  pwm_out_stage #(.TB_W(TB_W)) u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .en_i     (en_i),
    .tick_i   (tick_w),
    .wrap_i   (wrap_w),
    .tb_nxt_i (tb_nxt),
    .shadow_i (duty_shadow_o),
    .req_i    (req_w),
    .match_o  (match_w),
    .pwm_q    (pwm_o)
  );

endmodule

// File: rtl/pwm_dbuf_gen_chk.sv
module pwm_dbuf_gen_chk #(
  parameter int unsigned CNT_W = 8,
  parameter int unsigned SUB_W = 2,
  localparam int unsigned TB_W = CNT_W + SUB_W
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en_i,
  input logic [CNT_W-1:0] duty_hi_i,
  input logic [SUB_W-1:0] duty_lo_i,
  input logic             pwm_o,
  input logic [TB_W-1:0]  duty_shadow_o,
  input logic             tick_w,
  input logic             wrap_w,
  input logic             match_w,
  input logic [TB_W-1:0]  tb_q
);

  AST_SET_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap_w && ({duty_hi_i, duty_lo_i} != '0)) |=> pwm_o); // R2

  AST_ZERO_DUTY_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap_w && ({duty_hi_i, duty_lo_i} == '0)) |=> !pwm_o); // R2

  AST_RISE_ONLY_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap_w |=> !$rose(pwm_o)); // R2

  AST_SHADOW_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_w |=> (duty_shadow_o == $past({duty_hi_i, duty_lo_i}))); // R3

  AST_SHADOW_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap_w |=> $stable(duty_shadow_o)); // R4

  AST_TB_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_w |=> (tb_q == '0)); // R5

  AST_TB_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_w && !wrap_w) |=> (tb_q == TB_W'($past(tb_q) + 1'b1))); // R5

  AST_CLEAR_ON_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    match_w |=> !pwm_o); // R6

  AST_TB_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && !tick_w) |=> $stable(tb_q)); // R8

  AST_OFF_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> (!pwm_o && (tb_q == '0))); // R9

endmodule

bind pwm_dbuf_gen pwm_dbuf_gen_chk #(.CNT_W(CNT_W), .SUB_W(SUB_W)) chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .en_i          (en_i),
  .duty_hi_i     (duty_hi_i),
  .duty_lo_i     (duty_lo_i),
  .pwm_o         (pwm_o),
  .duty_shadow_o (duty_shadow_o),
  .tick_w        (tick_w),
  .wrap_w        (wrap_w),
  .match_w       (match_w),
  .tb_q          (tb_q)
);

// File: tb/pwm_dbuf_gen_tb_top.sv
module pwm_dbuf_gen_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en_i = 1'b0;
  logic [7:0] period_i = '0;
  logic [7:0] duty_hi_i = '0;
  logic [1:0] duty_lo_i = '0;
  logic [1:0] psc_sel_i = '0;
  logic       pwm_o;
  logic [9:0] duty_shadow_o;

  always #5 clk = ~clk;

  pwm_dbuf_gen dut_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .en_i          (en_i),
    .period_i      (period_i),
    .duty_hi_i     (duty_hi_i),
    .duty_lo_i     (duty_lo_i),
    .psc_sel_i     (psc_sel_i),
    .pwm_o         (pwm_o),
    .duty_shadow_o (duty_shadow_o)
  );

  int unsigned n_chk = 0;
  int unsigned n_bad = 0;
  bit          done = 1'b0;

  typedef struct packed {
    logic [7:0]  pr;
    logic [9:0]  d;
    logic [1:0]  sel;
    logic [15:0] t;   // expected period in clocks
    logic [15:0] h;   // expected high clocks per period
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{8'd3,   10'd8,    2'd0, 16'd16,   16'd8},    // R6 even duty
    '{8'd3,   10'd5,    2'd0, 16'd16,   16'd5},    // R6 odd duty, fine bits
    '{8'd9,   10'd13,   2'd1, 16'd160,  16'd52},   // R8 ratio 4
    '{8'd2,   10'd7,    2'd2, 16'd192,  16'd112},  // R8 ratio 16 (10)
    '{8'd1,   10'd3,    2'd3, 16'd128,  16'd48},   // R8 ratio 16 (11)
    '{8'd4,   10'd20,   2'd0, 16'd20,   16'd20},   // R7 duty equals length
    '{8'd4,   10'd0,    2'd0, 16'd20,   16'd0},    // R2 zero duty
    '{8'd0,   10'd1,    2'd0, 16'd4,    16'd1},    // R5 smallest period
    '{8'd255, 10'd1023, 2'd0, 16'd1024, 16'd1023}, // R6 last step match
    '{8'd7,   10'd100,  2'd1, 16'd128,  16'd128}   // R7 duty above length
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic set_duty(input logic [9:0] d);
    duty_hi_i = d[9:2];
    duty_lo_i = d[1:0];
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : main
    int unsigned highs, rises, first_rise, second_rise, cyc;
    logic prev;

    repeat (3) @(negedge clk);
    // R1: state while reset and right after release
    check(pwm_o == 1'b0, "R1 pwm at reset", pwm_o, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(pwm_o == 1'b0, "R1 pwm after reset", pwm_o, 0);
    check(duty_shadow_o == 10'd0, "R1 shadow after reset", duty_shadow_o, 0);

    // R9: first period after enable produces no high pulse
    period_i = 8'd1; psc_sel_i = 2'd0; set_duty(10'd6);
    en_i = 1'b1;
    highs = 0;
    for (int i = 0; i < 7; i++) begin
      @(negedge clk);
      if (pwm_o) highs++;
    end
    check(highs == 0, "R9 low before first boundary", highs, 0);
    check(duty_shadow_o == 10'd0, "R9 shadow before first boundary", duty_shadow_o, 0);
    @(negedge clk);
    check(pwm_o == 1'b1, "R2 rise at first boundary", pwm_o, 1);
    check(duty_shadow_o == 10'd6, "R3 shadow at first boundary", duty_shadow_o, 6);
    // R9: disable drops output on the next clock
    en_i = 1'b0;
    @(negedge clk);
    check(pwm_o == 1'b0, "R9 low after disable", pwm_o, 0);

    // Vector table
    for (int v = 0; v < NV; v++) begin
      en_i = 1'b0;
      period_i = VECS[v].pr;
      psc_sel_i = VECS[v].sel;
      set_duty(VECS[v].d);
      @(negedge clk);
      en_i = 1'b1;
      repeat (2 * int'(VECS[v].t)) @(negedge clk);
      check(duty_shadow_o == VECS[v].d, "R3 shadow value", duty_shadow_o, int'(VECS[v].d));
      highs = 0; rises = 0; first_rise = 0; second_rise = 0;
      prev = pwm_o;
      for (int c = 1; c <= 2 * int'(VECS[v].t); c++) begin
        @(negedge clk);
        if (pwm_o) highs++;
        if (pwm_o && !prev) begin
          rises++;
          if (rises == 1) first_rise = c;
          if (rises == 2) second_rise = c;
        end
        prev = pwm_o;
      end
      check(highs == 2 * int'(VECS[v].h), "R6/R7/R8 high clocks over two periods",
            highs, 2 * int'(VECS[v].h));
      if (VECS[v].h != 0 && VECS[v].h != VECS[v].t) begin
        check(rises == 2, "R5 one rise per period", rises, 2);
        check(second_rise - first_rise == int'(VECS[v].t), "R5 period length",
              second_rise - first_rise, int'(VECS[v].t));
      end else begin
        check(rises == 0, "R2/R7 no edges at 0% or 100%", rises, 0);
      end
    end

    // R4: rewrite duty just after a rising edge
    en_i = 1'b0;
    period_i = 8'd3; psc_sel_i = 2'd0; set_duty(10'd8);
    @(negedge clk);
    en_i = 1'b1;
    cyc = 0;
    while (pwm_o !== 1'b1 && cyc < 200) begin @(negedge clk); cyc++; end
    set_duty(10'd12);
    highs = 0;
    while (pwm_o === 1'b1 && highs < 100) begin
      highs++;
      check(duty_shadow_o == 10'd8, "R4 shadow held mid-period", duty_shadow_o, 8);
      @(negedge clk);
    end
    check(highs == 8, "R4 current period keeps old duty", highs, 8);
    cyc = 0;
    while (pwm_o !== 1'b1 && cyc < 200) begin @(negedge clk); cyc++; end
    check(duty_shadow_o == 10'd12, "R4 new duty at next boundary", duty_shadow_o, 12);
    highs = 0;
    while (pwm_o === 1'b1 && highs < 100) begin highs++; @(negedge clk); end
    check(highs == 12, "R4 next period uses new duty", highs, 12);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule